// File: doc/BRIEF.md
# Boot-Aware System Address Decoder

This block turns a 32-bit physical address into a routing decision for the memory side of a system: which target region is hit, which static chip-select slot is driven, which local offset the addressed device sees, and whether the access must be refused. The low 128 MB boot window has no storage behind it. It shows the internal ROM, static slot 0 or the internal boot SRAM, depending on the boot-mode input. Devices smaller than their window are aliased. The offset is the address masked to the real device size, so the device repeats across its window.

Static slots 2 to 5 can be taken over by a NAND or CF controller. A taken slot refuses accesses. There is one exception: if slot 2 is taken by NAND, the boot SRAM shows through that window. Writes that land on ROM, either directly or through the boot window, are refused. A request presented in one cycle produces a registered response in the next.

Top module: `addr_dec`

## Requirements
- R1: After reset, and in any cycle after a cycle with `req_valid_i` low, every response output is zero. A request with `req_valid_i` high gives `rsp_valid_o` high exactly one cycle later, and the response reflects that request and the configuration inputs sampled with it.
- R2: `rsp_sel_o` is one-hot or zero. Its bits are: bit0 internal ROM, bit1 boot SRAM, bit2 static slot, bit3 first DRAM controller, bit4 second DRAM controller, bit5 peripheral bus. A refused access has `rsp_err_o`=1, with `rsp_sel_o`, `rsp_cs_o` and `rsp_offset_o` all zero.
- R3: In the boot window 0x0000_0000–0x07FF_FFFF with `boot_mode_i`=2'b00, the internal ROM is selected, with offset address[14:0].
- R4: In the boot window with `boot_mode_i`=2'b01, static slot 0 is selected (sel bit2, `rsp_cs_o`=6'b000001), with offset address[26:0].
- R5: In the boot window with `boot_mode_i`=2'b10, the boot SRAM is selected, with offset address[11:0]. `boot_mode_i`=2'b11 refuses the boot window.
- R6: 0x0800_0000–0x0BFF_FFFF selects the internal ROM, with offset address[14:0] (32 KB aliased). 0x0C00_0000–0x0FFF_FFFF selects the boot SRAM, with offset address[11:0] (4 KB aliased).
- R7: A write (`req_write_i`=1) that resolves to the ROM, whether directly or through the boot window, is refused.
- R8: 0x1000_0000–0x3FFF_FFFF forms six 128 MB static slots. Slot k starts at 0x1000_0000 + k·0x0800_0000 and drives only `rsp_cs_o[k]` with sel bit2. The offset is address[26:0].
- R9: `slot_blk_i[j]`=1 marks static slot j+2 as owned by the NAND/CF controller. Accesses to that slot are refused, except as stated in R10.
- R10: When `slot_blk_i[0]`=1 and `slot2_nand_i`=1, the slot-2 window 0x2000_0000–0x27FF_FFFF selects the boot SRAM, with offset address[11:0] and no chip select.
- R11: 0x4000_0000–0x4FFF_FFFF selects the first DRAM controller, with offset address−0x4000_0000. 0x5000_0000–0x6FFF_FFFF selects the second, with offset address−0x5000_0000.
- R12: 0x7000_0000–0x7FFF_FFFF selects the peripheral bus, with offset address[27:0].
- R13: Addresses at 0x8000_0000 and above are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 2 | Source mirrored into the boot window |
| slot_blk_i | input | 4 | Bit j: static slot j+2 owned by the NAND/CF controller |
| slot2_nand_i | input | 1 | Slot 2 is owned by NAND (enables the SRAM mirror) |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | 32 | Physical address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_sel_o | output | 6 | One-hot region select |
| rsp_cs_o | output | 6 | Static chip-select vector |
| rsp_offset_o | output | 32 | Local device offset |
| rsp_err_o | output | 1 | Access refused |

## Verification
Two refusal rules can apply to the same access. A write through the boot window with boot mode 00 must be refused by the ROM write guard, even though the mirror itself resolved to a valid target. A write into slot 2 while it is blocked and NAND-owned must instead reach the SRAM mirror without an error. The bench drives both combinations directly, then sweeps random addresses, modes, block masks and write flags. A behavioural model, written with address-range comparisons and arithmetic offsets, predicts every response and is compared on every clock.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned N_SEL      = 6;
  localparam int unsigned N_SLOTS    = 6;
  localparam int unsigned FIRST_BLK  = 2;
  localparam int unsigned N_BLK      = 4;
  localparam int unsigned SLOT_W     = $clog2(N_SLOTS);
  localparam int unsigned ROM_OFF_W  = 15;
  localparam int unsigned SRAM_OFF_W = 12;
  localparam int unsigned SLOT_OFF_W = 27;
  localparam int unsigned WIN_OFF_W  = 28;
  localparam logic [AW-1:0] DRAM1_BASE = 32'h5000_0000;

  localparam int unsigned SEL_ROM  = 0;
  localparam int unsigned SEL_SRAM = 1;
  localparam int unsigned SEL_SLOT = 2;
  localparam int unsigned SEL_DRM0 = 3;
  localparam int unsigned SEL_DRM1 = 4;
  localparam int unsigned SEL_PERI = 5;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_ROM, TGT_SRAM, TGT_SLOT, TGT_DRAM0, TGT_DRAM1, TGT_PERI
  } tgt_e;

  typedef enum logic [1:0] {
    BOOT_ROM = 2'b00, BOOT_NOR = 2'b01, BOOT_NAND = 2'b10, BOOT_RSVD = 2'b11
  } boot_e;
endpackage

// File: rtl/addr_dec_map.sv
module addr_dec_map
  import addr_dec_pkg::*;
(
  input  logic [AW-1:26]     addr_hi_i,
  input  logic [1:0]         boot_mode_i,
  input  logic [N_BLK-1:0]   slot_blk_i,
  input  logic               slot2_nand_i,
  output tgt_e               tgt_o,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [N_SLOTS-1:0] blk_v;
  logic [3:0]         win;
  logic [SLOT_W-1:0]  s_idx;

  genvar k;
  generate
    for (k = 0; k < N_SLOTS; k++) begin : g_blk
      if (k >= FIRST_BLK && k < FIRST_BLK + N_BLK) begin : g_on
        assign blk_v[k] = slot_blk_i[k-FIRST_BLK];
      end else begin : g_off
        assign blk_v[k] = 1'b0;
      end
    end
  endgenerate

  assign win   = addr_hi_i[30:27];
  assign s_idx = SLOT_W'(win[2:0] - 3'd2);

  always_comb begin
    tgt_o  = TGT_NONE;
    slot_o = '0;
    if (!addr_hi_i[31]) begin
      unique case (win)
        4'd0: begin
          unique case (boot_e'(boot_mode_i))
            BOOT_ROM:  tgt_o = TGT_ROM;
            BOOT_NOR:  tgt_o = TGT_SLOT;
            BOOT_NAND: tgt_o = TGT_SRAM;
            default:   tgt_o = TGT_NONE;
          endcase
        end
        4'd1: tgt_o = addr_hi_i[26] ? TGT_SRAM : TGT_ROM;
        4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
          slot_o = s_idx;
          if (!blk_v[s_idx])                           tgt_o = TGT_SLOT;
          else if (s_idx == SLOT_W'(2) && slot2_nand_i) tgt_o = TGT_SRAM;
          else                                         tgt_o = TGT_NONE;
        end
        4'd8, 4'd9:                 tgt_o = TGT_DRAM0;
        4'd10, 4'd11, 4'd12, 4'd13: tgt_o = TGT_DRAM1;
        default:                    tgt_o = TGT_PERI;
      endcase
    end
  end
endmodule

// File: rtl/addr_dec_out.sv
module addr_dec_out
  import addr_dec_pkg::*;
(
  input  tgt_e                tgt_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                write_i,
  output logic [N_SEL-1:0]    sel_o,
  output logic [N_SLOTS-1:0]  cs_o,
  output logic [AW-1:0]       offset_o,
  output logic                err_o
);
  logic [N_SEL-1:0] sel_raw;
  logic [AW-1:0]    off_raw;

  assign err_o = (tgt_i == TGT_NONE) || (tgt_i == TGT_ROM && write_i);

  always_comb begin
    sel_raw = '0;
    off_raw = '0;
    unique case (tgt_i)
      TGT_ROM:   begin sel_raw[SEL_ROM]  = 1'b1; off_raw = AW'(addr_i[ROM_OFF_W-1:0]);  end
      TGT_SRAM:  begin sel_raw[SEL_SRAM] = 1'b1; off_raw = AW'(addr_i[SRAM_OFF_W-1:0]); end
      TGT_SLOT:  begin sel_raw[SEL_SLOT] = 1'b1; off_raw = AW'(addr_i[SLOT_OFF_W-1:0]); end
      TGT_DRAM0: begin sel_raw[SEL_DRM0] = 1'b1; off_raw = AW'(addr_i[WIN_OFF_W-1:0]);  end
      TGT_DRAM1: begin sel_raw[SEL_DRM1] = 1'b1; off_raw = addr_i - DRAM1_BASE;         end
      TGT_PERI:  begin sel_raw[SEL_PERI] = 1'b1; off_raw = AW'(addr_i[WIN_OFF_W-1:0]);  end
      default:   ;
    endcase
  end

  assign sel_o    = err_o ? '0 : sel_raw;
  assign offset_o = err_o ? '0 : off_raw;

  genvar k;
  generate
    for (k = 0; k < N_SLOTS; k++) begin : g_cs
      assign cs_o[k] = !err_o && (tgt_i == TGT_SLOT) && (slot_i == SLOT_W'(k));
    end
  endgenerate
endmodule

// File: rtl/addr_dec.sv
module addr_dec
  import addr_dec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          boot_mode_i,
  input  logic [N_BLK-1:0]    slot_blk_i,
  input  logic                slot2_nand_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [AW-1:0]       req_addr_i,
  output logic                rsp_valid_o,
  output logic [N_SEL-1:0]    rsp_sel_o,
  output logic [N_SLOTS-1:0]  rsp_cs_o,
  output logic [AW-1:0]       rsp_offset_o,
  output logic                rsp_err_o
);
  tgt_e               tgt;
  logic [SLOT_W-1:0]  slot;
  logic [N_SEL-1:0]   d_sel;
  logic [N_SLOTS-1:0] d_cs;
  logic [AW-1:0]      d_off;
  logic               d_err;

  addr_dec_map u_map (
    .addr_hi_i    (req_addr_i[AW-1:26]),
    .boot_mode_i  (boot_mode_i),
    .slot_blk_i   (slot_blk_i),
    .slot2_nand_i (slot2_nand_i),
    .tgt_o        (tgt),
    .slot_o       (slot)
  );

  addr_dec_out u_out (
    .tgt_i    (tgt),
    .slot_i   (slot),
    .addr_i   (req_addr_i),
    .write_i  (req_write_i),
    .sel_o    (d_sel),
    .cs_o     (d_cs),
    .offset_o (d_off),
    .err_o    (d_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_sel_o    <= '0;
      rsp_cs_o     <= '0;
      rsp_offset_o <= '0;
      rsp_err_o    <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_sel_o    <= req_valid_i ? d_sel : '0;
      rsp_cs_o     <= req_valid_i ? d_cs  : '0;
      rsp_offset_o <= req_valid_i ? d_off : '0;
      rsp_err_o    <= req_valid_i && d_err;
    end
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_sel_o == '0 && !rsp_err_o));
  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_sel_o));
  a_r2_err_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_sel_o == '0 && rsp_cs_o == '0 && rsp_offset_o == '0));
  a_r8_cs_needs_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_cs_o != '0) |-> (rsp_sel_o[SEL_SLOT] && $onehot(rsp_cs_o)));
  a_r6_rom_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_sel_o[SEL_ROM] |-> (rsp_offset_o[AW-1:ROM_OFF_W] == '0));
  a_r7_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i[31:26] == 6'b000010) |=> rsp_err_o);
  a_r12_peri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[31:28] == 4'h7) |=> (rsp_sel_o == 6'b100000));
  a_r13_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[31]) |=> rsp_err_o);
endmodule

// File: tb/addr_dec_bench.sv
module addr_dec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  boot_mode_i = 2'b00;
  logic [3:0]  slot_blk_i = 4'b0000;
  logic        slot2_nand_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o;
  logic [5:0]  rsp_sel_o;
  logic [5:0]  rsp_cs_o;
  logic [31:0] rsp_offset_o;
  logic        rsp_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic        e_valid = 0, e_err = 0;
  logic [5:0]  e_sel = '0, e_cs = '0;
  logic [31:0] e_off = '0;
  string       e_tag = "R1";

  addr_dec u_addr_dec (.*);

  always #5 clk_i = ~clk_i;

  function automatic void model(input logic v, input logic w, input logic [31:0] a,
      input logic [1:0] m, input logic [3:0] b, input logic n,
      output logic ov, output logic [5:0] os, output logic [5:0] oc,
      output logic [31:0] oo, output logic oe, output string tag);
    int tgt; // 0 none 1 rom 2 sram 3 slot 4 dram0 5 dram1 6 peri
    int slot;
    longint unsigned x;
    x = a; slot = 0; tgt = 0; os = '0; oc = '0; oo = '0; oe = 0; ov = v;
    if (!v) begin tag = "R1"; return; end
    if (x < 64'h0800_0000) begin
      if (m == 2'b00) begin tgt = 1; tag = "R3"; end
      else if (m == 2'b01) begin tgt = 3; slot = 0; tag = "R4"; end
      else if (m == 2'b10) begin tgt = 2; tag = "R5"; end
      else begin tgt = 0; tag = "R5"; end
    end else if (x < 64'h0C00_0000) begin tgt = 1; tag = "R6"; end
    else if (x < 64'h1000_0000) begin tgt = 2; tag = "R6"; end
    else if (x < 64'h4000_0000) begin
      slot = int'((x - 64'h1000_0000) / 64'h0800_0000);
      tag = "R8";
      if (slot >= 2 && b[slot-2]) begin
        if (slot == 2 && n) begin tgt = 2; tag = "R10"; end
        else begin tgt = 0; tag = "R9"; end
      end else tgt = 3;
    end else if (x < 64'h5000_0000) begin tgt = 4; tag = "R11"; end
    else if (x < 64'h7000_0000) begin tgt = 5; tag = "R11"; end
    else if (x < 64'h8000_0000) begin tgt = 6; tag = "R12"; end
    else begin tgt = 0; tag = "R13"; end
    if (tgt == 1 && w) begin tgt = 0; tag = "R7"; end
    case (tgt)
      1: begin os = 6'b000001; oo = 32'(x % 32768); end
      2: begin os = 6'b000010; oo = 32'(x % 4096); end
      3: begin os = 6'b000100; oc = 6'(1 << slot); oo = 32'(x % 64'h0800_0000); end
      4: begin os = 6'b001000; oo = 32'(x - 64'h4000_0000); end
      5: begin os = 6'b010000; oo = 32'(x - 64'h5000_0000); end
      6: begin os = 6'b100000; oo = 32'(x - 64'h7000_0000); end
      default: oe = 1;
    endcase
  endfunction

  task automatic check_out();
    checks++;
    if (rsp_valid_o !== e_valid || rsp_sel_o !== e_sel || rsp_cs_o !== e_cs ||
        rsp_offset_o !== e_off || rsp_err_o !== e_err) begin
      errors++;
      $display("FAIL %s: act v=%b sel=%b cs=%b off=%h err=%b exp v=%b sel=%b cs=%b off=%h err=%b",
               e_tag, rsp_valid_o, rsp_sel_o, rsp_cs_o, rsp_offset_o, rsp_err_o,
               e_valid, e_sel, e_cs, e_off, e_err);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [31:0] a,
                      input logic [1:0] m, input logic [3:0] b, input logic n);
    @(negedge clk_i);
    check_out();
    req_valid_i = v; req_write_i = w; req_addr_i = a;
    boot_mode_i = m; slot_blk_i = b; slot2_nand_i = n;
    model(v, w, a, m, b, n, e_valid, e_sel, e_cs, e_off, e_err, e_tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act cycles=%0d exp completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    e_tag = "R1";
    check_out(); // R1 reset state
    rst_ni = 1'b1;
    // R1 idle and latency
    step(0, 0, 32'h0800_0000, 2'b00, 4'h0, 0);
    // R3 boot from ROM, aliasing
    step(1, 0, 32'h0000_1234, 2'b00, 4'h0, 0);
    step(1, 0, 32'h07FF_FFFF, 2'b00, 4'h0, 0);
    // R7 write through boot mirror to ROM, alongside the mirror
    step(1, 1, 32'h0000_0040, 2'b00, 4'h0, 0);
    // R4 NOR boot
    step(1, 1, 32'h0123_4567, 2'b01, 4'h0, 0);
    // R5 NAND boot, reserved mode
    step(1, 0, 32'h0000_5ABC, 2'b10, 4'h0, 0);
    step(1, 0, 32'h0000_0010, 2'b11, 4'h0, 0);
    // R6 ROM and SRAM windows
    step(1, 0, 32'h0800_8001, 2'b01, 4'h0, 0);
    step(1, 0, 32'h0BFF_FFFF, 2'b01, 4'h0, 0);
    step(1, 1, 32'h0C00_1FFF, 2'b00, 4'h0, 0);
    step(1, 0, 32'h0FFF_F000, 2'b00, 4'h0, 0);
    // R7 direct ROM write
    step(1, 1, 32'h0A00_0000, 2'b10, 4'h0, 0);
    // R8 every slot boundary
    for (int k = 0; k < 6; k++) begin
      step(1, 0, 32'h1000_0000 + 32'(k) * 32'h0800_0000, 2'b00, 4'h0, 0);
      step(1, 1, 32'h17FF_FFFF + 32'(k) * 32'h0800_0000, 2'b00, 4'h0, 0);
    end
    // R9 blocked slots 2..5, slot 0/1 unaffected
    for (int j = 0; j < 4; j++)
      step(1, 0, 32'h2000_0100 + 32'(j) * 32'h0800_0000, 2'b00, 4'(1 << j), 0);
    step(1, 0, 32'h1800_0000, 2'b00, 4'hF, 0);
    // R10 NAND mirror in slot 2, with a write; CF in slot 2 still refused
    step(1, 1, 32'h2000_3ABC, 2'b00, 4'h1, 1);
    step(1, 0, 32'h27FF_FFFF, 2'b10, 4'h1, 1);
    step(1, 0, 32'h2000_0000, 2'b10, 4'h1, 0);
    step(1, 0, 32'h2800_0000, 2'b10, 4'h2, 1);
    // R11 DRAM windows
    step(1, 0, 32'h4000_0000, 2'b00, 4'h0, 0);
    step(1, 1, 32'h4FFF_FFFF, 2'b00, 4'h0, 0);
    step(1, 0, 32'h5000_0000, 2'b00, 4'h0, 0);
    step(1, 0, 32'h6FFF_FFFF, 2'b00, 4'h0, 0);
    // R12 peripheral, R13 high space
    step(1, 0, 32'h7000_0004, 2'b00, 4'h0, 0);
    step(1, 1, 32'h7FFF_FFFF, 2'b00, 4'h0, 0);
    step(1, 0, 32'h8000_0000, 2'b00, 4'h0, 0);
    step(1, 1, 32'hFFFF_FFFF, 2'b00, 4'h0, 0);
    // R1 back-to-back then idle
    step(0, 0, 32'h0000_0000, 2'b00, 4'h0, 0);
    // random sweep over all requirements
    for (int i = 0; i < 4000; i++)
      step(1'($urandom_range(0, 7) != 0), 1'($urandom), $urandom,
           2'($urandom), 4'($urandom), 1'($urandom));
    step(0, 0, 32'h0, 2'b00, 4'h0, 0);
    step(0, 0, 32'h0, 2'b00, 4'h0, 0);
    finish_run();
  end
endmodule